// File: doc/BRIEF.md
# Parallel SCSI Bus Line Register Interface

This block is a small byte-wide register file that a host processor uses to control a parallel SCSI bus directly, one line at a time. Writes set the initiator-side control lines, the target-side phase lines, an outgoing data byte and a mode byte. Reads return what is really on the bus, not what was written. The sampled bus is this block's own drive wire-ORed with every other device's drive.

All line requests are merged into one active-high output vector. A test-mode bit releases every line at once without losing the stored settings. Arbitration timing is done by a companion block, which reports two status flags that appear in the readback. The DMA-start register slots are decoded, but writing them does nothing.

Bus vectors are active-high and 18 bits wide, with this layout: data [7:0], parity 8, I/O 9, C/D 10, MSG 11, REQ 12, ACK 13, ATN 14, SEL 15, BSY 16, RST 17.

Top module: `scsi_regif`

## Requirements
- R1: Only address bits [2:0] choose a register. Higher address bits have no effect on writes or reads.
- R2: A write to register 1 sets RST from bit 7, ACK from bit 4, BSY from bit 3, SEL from bit 2 and ATN from bit 1. These drive on the cycle after the write, and each write replaces all five.
- R3: The byte written to register 0 is driven onto data [7:0] only while register 1 bit 0 is set. Otherwise the data lines are released (0).
- R4: While register 1 bit 6 (test mode) is set, the whole output vector is 0. Clearing the bit restores the drive from the stored registers.
- R5: A read of register 1 returns the stored byte, with bit 6 replaced by the arbitration-active input and bit 5 replaced by the arbitration-lost input.
- R6: A write to register 3 drives REQ from bit 3, MSG from bit 2, C/D from bit 1 and I/O from bit 0. A read of register 3 returns the sampled REQ, MSG, C/D and I/O lines in those same bits, with the upper bits 0.
- R7: A read of register 4 returns the sampled lines as RST bit 7, BSY 6, REQ 5, MSG 4, C/D 3, I/O 2, SEL 1, parity 0.
- R8: A read of register 5 returns phase-match in bit 3, sampled ATN in bit 1 and sampled ACK in bit 0, with all other bits 0. Phase-match is 1 when the MSG, C/D and I/O bits requested in register 3 equal the sampled ones, whatever the state of test mode.
- R9: A read of register 0 returns the sampled data lines. A read of register 2 returns the stored mode byte. Reads of registers 6 and 7 return 0xFF.
- R10: Writes to registers 4 to 7 change neither the output nor any readback. The parity line is never driven.
- R11: A synchronous active-high reset clears every register, so the output is 0 and registers 1, 2 and 3 read back as 0 when the bus is idle.
- R12: The sampled bus is the output vector ORed with the external bus input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | ADDR_W (4) | Register address; only bits [2:0] decode |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Combinational read byte for `addr` |
| arb_active | input | 1 | Arbitration-in-progress flag from the companion block |
| arb_lost | input | 1 | Arbitration-lost flag from the companion block |
| bus_in | input | 18 | Lines driven by other devices |
| bus_out | output | 18 | Lines driven by this block |

## Verification
On every cycle, the assertions check the following:
- the effect of a register 1 write on the control lines, data release and test-mode release;
- that the parity line is never driven and that writes to the upper registers leave the output untouched;
- the fixed 0xFF reads and the live register 3 and register 1 readback against the ports.

Only the bench scenarios can show that the stored values survive test mode and come back once it is cleared, and that phase-match tracks a mismatch on each of MSG, C/D and I/O. The same holds for the packing of the status byte, the wire-OR of the external lines into every readback, and the effect of reset in the middle of a run.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_SEL_W = 3;
    localparam int PHASE_W   = 4;

    // Register 1 bit positions (decoded by the line driver and the read mux)
    localparam int IC_RST  = 7;
    localparam int IC_TEST = 6;
    localparam int IC_ARBL = 5;
    localparam int IC_ACK  = 4;
    localparam int IC_BSY  = 3;
    localparam int IC_SEL  = 2;
    localparam int IC_ATN  = 1;
    localparam int IC_DOUT = 0;

    // Register 3 bit positions
    localparam int TC_REQ = 3;
    localparam int TC_MSG = 2;
    localparam int TC_CD  = 1;
    localparam int TC_IO  = 0;

    typedef enum logic [REG_SEL_W-1:0] {
        RA_DATA   = 3'd0,
        RA_ICMD   = 3'd1,
        RA_MODE   = 3'd2,
        RA_TCMD   = 3'd3,
        RA_LINES  = 3'd4,
        RA_PHASE  = 3'd5,
        RA_XFER_A = 3'd6,
        RA_XFER_B = 3'd7
    } reg_addr_e;

    // Active-high bus lines, MSB first: rst at bit 17 down to data at [7:0]
    typedef struct packed {
        logic              rst;
        logic              bsy;
        logic              sel;
        logic              atn;
        logic              ack;
        logic              req;
        logic              msg;
        logic              cd;
        logic              io;
        logic              par;
        logic [BYTE_W-1:0] data;
    } bus_t;

    localparam int BUS_W = $bits(bus_t);

    typedef struct packed {
        logic [BYTE_W-1:0]  data;
        logic [BYTE_W-1:0]  icmd;
        logic [BYTE_W-1:0]  mode;
        logic [PHASE_W-1:0] tcmd;
    } regs_t;

    function automatic logic [BYTE_W-1:0] pack_lines(bus_t s);
        return {s.rst, s.bsy, s.req, s.msg, s.cd, s.io, s.sel, s.par};
    endfunction

    function automatic logic phase_equal(logic [2:0] want, bus_t s);
        return want == {s.msg, s.cd, s.io};
    endfunction

endpackage

// File: rtl/scsi_regif_bank.sv
module scsi_regif_bank
    import scsi_regif_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  reg_addr_e               sel,
    input  logic [BYTE_W-1:0]       wr_data,
    output regs_t                   regs
);

    regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                RA_DATA: regs_q.data <= wr_data;
                RA_ICMD: regs_q.icmd <= wr_data;
                RA_MODE: regs_q.mode <= wr_data;
                RA_TCMD: regs_q.tcmd <= wr_data[PHASE_W-1:0];
                default: ; // transfer-start slots: accepted, no effect
            endcase
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/scsi_regif_drive.sv
module scsi_regif_drive
    import scsi_regif_pkg::*;
(
    input  logic [BYTE_W-1:0]  icmd,
    input  logic [PHASE_W-1:0] tcmd,
    input  logic [BYTE_W-1:0]  data,
    output logic [2:0]         phase_req,
    output bus_t               bus_drv
);

    bus_t              req_lines;
    logic [BYTE_W-1:0] data_gated;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_data_gate
        assign data_gated[b] = data[b] & icmd[IC_DOUT];
    end

    always_comb begin
        req_lines      = '0;
        req_lines.rst  = icmd[IC_RST];
        req_lines.ack  = icmd[IC_ACK];
        req_lines.bsy  = icmd[IC_BSY];
        req_lines.sel  = icmd[IC_SEL];
        req_lines.atn  = icmd[IC_ATN];
        req_lines.req  = tcmd[TC_REQ];
        req_lines.msg  = tcmd[TC_MSG];
        req_lines.cd   = tcmd[TC_CD];
        req_lines.io   = tcmd[TC_IO];
        req_lines.par  = 1'b0;
        req_lines.data = data_gated;
    end

    assign bus_drv   = icmd[IC_TEST] ? bus_t'('0) : req_lines;
    assign phase_req = {req_lines.msg, req_lines.cd, req_lines.io};

    logic icmd_unused;
    assign icmd_unused = icmd[IC_ARBL];

endmodule

// File: rtl/scsi_regif_rdmux.sv
module scsi_regif_rdmux
    import scsi_regif_pkg::*;
(
    input  reg_addr_e         sel,
    input  regs_t             regs,
    input  logic [2:0]        phase_req,
    input  bus_t              sampled,
    input  logic              arb_active,
    input  logic              arb_lost,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] icmd_view;
    logic [BYTE_W-1:0] phase_view;
    logic [BYTE_W-1:0] tcmd_view;

    always_comb begin
        icmd_view          = regs.icmd;
        icmd_view[IC_TEST] = arb_active;
        icmd_view[IC_ARBL] = arb_lost;

        phase_view    = '0;
        phase_view[3] = phase_equal(phase_req, sampled);
        phase_view[1] = sampled.atn;
        phase_view[0] = sampled.ack;

        tcmd_view = '0;
        tcmd_view[PHASE_W-1:0] = {sampled.req, sampled.msg, sampled.cd, sampled.io};
    end

    always_comb begin
        unique case (sel)
            RA_DATA:  rd_data = sampled.data;
            RA_ICMD:  rd_data = icmd_view;
            RA_MODE:  rd_data = regs.mode;
            RA_TCMD:  rd_data = tcmd_view;
            RA_LINES: rd_data = pack_lines(sampled);
            RA_PHASE: rd_data = phase_view;
            default:  rd_data = '1;
        endcase
    end

    logic regs_unused;
    assign regs_unused = ^{regs.data, regs.tcmd};

endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
    import scsi_regif_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic                arb_active,
    input  logic                arb_lost,
    input  logic [BUS_W-1:0]    bus_in,
    output logic [BUS_W-1:0]    bus_out
);

    reg_addr_e  sel;
    regs_t      regs;
    bus_t       bus_drv;
    bus_t       sampled;
    logic [2:0] phase_req;

    assign sel = reg_addr_e'(addr[REG_SEL_W-1:0]);

    if (ADDR_W > REG_SEL_W) begin : g_addr_hi
        logic addr_unused;
        assign addr_unused = ^addr[ADDR_W-1:REG_SEL_W];
    end

    scsi_regif_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .regs    (regs)
    );

    scsi_regif_drive u_drive (
        .icmd      (regs.icmd),
        .tcmd      (regs.tcmd),
        .data      (regs.data),
        .phase_req (phase_req),
        .bus_drv   (bus_drv)
    );

    assign sampled = bus_t'(bus_in) | bus_drv;

    scsi_regif_rdmux u_rdmux (
        .sel        (sel),
        .regs       (regs),
        .phase_req  (phase_req),
        .sampled    (sampled),
        .arb_active (arb_active),
        .arb_lost   (arb_lost),
        .rd_data    (rd_data)
    );

    assign bus_out = bus_drv;

endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk
    import scsi_regif_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [BYTE_W-1:0]   wr_data,
    input logic [BYTE_W-1:0]   rd_data,
    input logic                arb_active,
    input logic                arb_lost,
    input logic [BUS_W-1:0]    bus_in,
    input logic [BUS_W-1:0]    bus_out
);

    logic [REG_SEL_W-1:0] a;
    logic [BUS_W-1:0]     smp;
    assign a   = addr[REG_SEL_W-1:0];
    assign smp = bus_out | bus_in;

    if (ADDR_W > REG_SEL_W) begin : g_hi
        logic chk_addr_unused;
        assign chk_addr_unused = ^addr[ADDR_W-1:REG_SEL_W];
    end

    // R2
    ctl_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && a == 3'd1 && !wr_data[6]) |=>
        bus_out[17:13] == {$past(wr_data[7]), $past(wr_data[3]), $past(wr_data[2]),
                           $past(wr_data[1]), $past(wr_data[4])});

    // R3
    data_release_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && a == 3'd1 && !wr_data[0]) |=> bus_out[7:0] == '0);

    // R4
    test_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && a == 3'd1 && wr_data[6]) |=> bus_out == '0);

    // R10
    parity_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bus_out[8] == 1'b0);

    // R10
    upper_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && a[2]) |=> bus_out == $past(bus_out));

    // R9
    fixed_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (a[2:1] == 2'b11) |-> rd_data == 8'hFF);

    // R6
    phase_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (a == 3'd3) |-> rd_data == {4'b0, smp[12:9]});

    // R5
    arb_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (a == 3'd1) |-> (rd_data[6] == arb_active && rd_data[5] == arb_lost));

endmodule

bind scsi_regif scsi_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .arb_active (arb_active),
    .arb_lost   (arb_lost),
    .bus_in     (bus_in),
    .bus_out    (bus_out)
);

// File: tb/tb_scsi_regif.sv
`timescale 1ns/1ps
module tb_scsi_regif;

    localparam int AW = 4;
    localparam int BW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          arb_active = 1'b0;
    logic          arb_lost = 1'b0;
    logic [BW-1:0] bus_in = '0;
    logic [BW-1:0] bus_out;

    always #5 clk = ~clk;

    scsi_regif #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .arb_active(arb_active), .arb_lost(arb_lost),
        .bus_in(bus_in), .bus_out(bus_out)
    );

    typedef struct {
        bit            is_bus;
        logic [BW-1:0] exp;
        string         tag;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    // Monitor: compares queued expectations once outputs settle in the cycle.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (q.size() > 0) begin
                item_t it;
                logic [BW-1:0] act;
                it  = q.pop_front();
                act = it.is_bus ? bus_out : {10'b0, rd_data};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver tasks: each starts and ends at a falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic exp_rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_bus = 1'b0; it.exp = {10'b0, e}; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_bus(input logic [BW-1:0] e, input string tag);
        item_t it;
        it.is_bus = 1'b1; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        exp_bus(18'h0, "R11 bus after reset");
        exp_rd(4'd1, 8'h00, "R11 reg1 after reset");
        exp_rd(4'd2, 8'h00, "R11 reg2 after reset");

        // R2 R3 control lines plus data drive
        wr(4'd0, 8'hA5);
        wr(4'd1, 8'h9F);
        exp_bus(18'h3E0A5, "R2 R3 all control lines and data");

        // R5 arbitration flags replace bits 6 and 5
        arb_active = 1'b1;
        exp_rd(4'd1, 8'hDF, "R5 arb active");
        arb_active = 1'b0; arb_lost = 1'b1;
        exp_rd(4'd1, 8'hBF, "R5 arb lost");
        arb_lost = 1'b0;

        // R2 replace, R3 release
        wr(4'd1, 8'h02);
        exp_bus(18'h04000, "R2 R3 only ATN, data released");

        // R6 phase lines
        wr(4'd3, 8'h0F);
        exp_bus(18'h05E00, "R6 phase lines driven");
        exp_rd(4'd3, 8'h0F, "R6 phase readback");

        // R8 phase match, ATN, ACK
        exp_rd(4'd5, 8'h0A, "R8 match with ATN");
        bus_in = 18'h02000;
        exp_rd(4'd5, 8'h0B, "R8 external ACK");
        wr(4'd3, 8'h08);
        bus_in = 18'h00400;
        exp_rd(4'd5, 8'h02, "R8 C/D mismatch");
        bus_in = 18'h00800;
        exp_rd(4'd5, 8'h02, "R8 MSG mismatch");
        bus_in = 18'h00200;
        exp_rd(4'd5, 8'h02, "R8 I/O mismatch");
        exp_rd(4'd3, 8'h09, "R6 R12 readback includes external I/O");
        bus_in = 18'h0;
        exp_rd(4'd5, 8'h0A, "R8 match restored");

        // R7 R12 line status packing
        bus_in = 18'h28100;
        exp_rd(4'd4, 8'hA3, "R7 R12 status byte");

        // R9 R12 data readback
        bus_in = 18'h0000F;
        exp_rd(4'd0, 8'h0F, "R9 external data only");
        wr(4'd1, 8'h03);
        exp_rd(4'd0, 8'hAF, "R9 R12 data wire-OR");
        bus_in = 18'h0;

        // R9 mode, fixed reads
        wr(4'd2, 8'h5A);
        exp_rd(4'd2, 8'h5A, "R9 mode readback");
        exp_rd(4'd6, 8'hFF, "R9 reg6");
        exp_rd(4'd7, 8'hFF, "R9 reg7");

        // R10 upper writes inert
        wr(4'd4, 8'hFF);
        wr(4'd5, 8'hFF);
        wr(4'd6, 8'hFF);
        wr(4'd7, 8'hFF);
        exp_bus(18'h050A5, "R10 bus unchanged");
        exp_rd(4'd1, 8'h03, "R10 reg1 unchanged");
        exp_rd(4'd2, 8'h5A, "R10 mode unchanged");
        exp_rd(4'd0, 8'hA5, "R10 data unchanged");

        // R1 R4 upper address bit ignored, test mode
        wr(4'h9, 8'h41);
        exp_bus(18'h0, "R1 R4 test mode via aliased address");
        exp_rd(4'hA, 8'h5A, "R1 aliased mode read");
        exp_rd(4'd5, 8'h08, "R4 R8 phase match uses stored request");
        wr(4'd1, 8'h01);
        exp_bus(18'h010A5, "R4 drive restored after test mode");

        // R11 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_bus(18'h0, "R11 bus after mid-run reset");
        exp_rd(4'd2, 8'h00, "R11 mode after mid-run reset");
        exp_rd(4'd3, 8'h00, "R11 phase after mid-run reset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule